// File: doc/BRIEF.md
# Hashed MAC Address Lookup Engine

This block turns a 48-bit destination MAC address into an egress port number for a switch forwarding path. Each request is hashed to an 11-bit bucket index, the bucket is read from a 2048-entry synchronous on-chip table, and the stored address is compared exactly with the request. The result is either a port number with the entry's filter and secure attributes, or a no-match indication. Each bucket holds one entry; there is no chaining.

Requests enter on a valid/ready stream and results leave on a valid/ready stream. The pipeline is two stages deep and takes one request per cycle. When the consumer withholds `res_ready` while a result is waiting, the whole pipeline freezes and `req_ready` drops in the same cycle. Nothing is lost and nothing is reordered. A configuration pin selects the hash per request. A plain write port lets the surrounding learning and aging logic fill the table.

Top module: `maclu_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 exactly when `res_valid` is 1 and `res_ready` is 0.
- R3: With `res_ready` held high, the result of a request accepted in cycle N is presented with `res_valid` high in cycle N+2. Back-to-back requests give back-to-back results in order.
- R4: While `res_valid` is 1 and `res_ready` is 0, every result output holds its value and no request is accepted.
- R5: With `cfg_hash_sel` = 0, the bucket index is the request address bits [10:0].
- R6: With `cfg_hash_sel` = 1, the bucket index is the XOR of address slices [10:0], [21:11], [32:22], [43:33], and bits [47:44] zero-extended to 11 bits.
- R7: A hit requires three things: the entry's valid bit is set, all 48 stored address bits equal the request, and the stored port is not 31. Port 31 is reserved and never reported with `res_hit` = 1.
- R8: On a hit, `res_hit` is 1 and `res_port`, `res_filter` and `res_secure` carry the entry's port, filter and secure fields.
- R9: On a miss, `res_hit` is 0, `res_port` is 31, and `res_filter` and `res_secure` are 0.
- R10: When `tbl_we` is 1, `tbl_wdata` is stored at `tbl_idx` on the clock edge. The layout is [57] valid, [56:9] MAC, [8:4] port, [3] secure, [2] filter, [1] newly-learned, [0] aging. A request accepted in any later cycle sees the new contents.
- R11: If a table write and an accepted request hit the same bucket in the same cycle, the lookup uses the contents from before that write.
- R12: `cfg_hash_sel` is sampled at acceptance, so consecutive requests may each use a different hash.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can take a request this cycle |
| req_mac | input | 48 | Destination address to resolve |
| cfg_hash_sel | input | 1 | 0: low-bits index, 1: XOR-fold index |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_hit | output | 1 | 1 when the address matched an entry |
| res_port | output | 5 | Egress port, 31 on miss |
| res_filter | output | 1 | Filter flag of the matched entry |
| res_secure | output | 1 | Secure flag of the matched entry |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 11 | Bucket written |
| tbl_wdata | input | 58 | Entry written (layout in R10) |

## Verification
A table write and a lookup read can land on the same bucket in the same cycle. This can also happen while an earlier lookup is frozen behind a stalled result. The bench provokes the directed case by writing a new port into the bucket of the request it presents in that cycle. The randomized phase also writes into the buckets of pooled addresses while requests and stalls are in flight. The reference model records each expected result at the moment of acceptance, before it applies that cycle's write. It then compares the DUT's output against this record on every clock, so a lookup that sees the new contents or a changed value during a stall is reported.

// File: rtl/maclu_pkg.sv
package maclu_pkg;
  localparam int MAC_W  = 48;
  localparam int PORT_W = 5;
  localparam int IDX_W  = 11;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int NSLICE = (MAC_W + IDX_W - 1) / IDX_W;
  localparam logic [PORT_W-1:0] NOMATCH_PORT = {PORT_W{1'b1}};

  typedef struct packed {
    logic              valid;
    logic [MAC_W-1:0]  mac;
    logic [PORT_W-1:0] port;
    logic              secure;
    logic              filter;
    logic              newf;
    logic              age;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  // XOR of all IDX_W-bit slices of the address, top slice zero-padded
  function automatic logic [IDX_W-1:0] xor_fold(input logic [MAC_W-1:0] mac);
    logic [NSLICE*IDX_W-1:0] ext;
    logic [IDX_W-1:0]        acc;
    ext = '0;
    ext[MAC_W-1:0] = mac;
    acc = '0;
    for (int i = 0; i < NSLICE; i++) acc ^= ext[i*IDX_W +: IDX_W];
    return acc;
  endfunction
endpackage

// File: rtl/maclu_hash.sv
module maclu_hash import maclu_pkg::*; (
  input  logic             sel,
  input  logic [MAC_W-1:0] mac,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    if (sel) idx = xor_fold(mac);
    else     idx = mac[IDX_W-1:0];
  end
endmodule

// File: rtl/maclu_ram.sv
module maclu_ram #(
  parameter int AW = 11,
  parameter int DW = 58
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  // read returns the word as it was before a same-edge write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/maclu_match.sv
module maclu_match import maclu_pkg::*; (
  input  entry_t            ent,
  input  logic [MAC_W-1:0]  key,
  output logic              hit,
  output logic [PORT_W-1:0] port,
  output logic              filter,
  output logic              secure
);
  logic unused_flags;
  assign unused_flags = ent.newf ^ ent.age;

  always_comb begin
    hit    = ent.valid && (ent.mac == key) && (ent.port != NOMATCH_PORT);
    port   = hit ? ent.port : NOMATCH_PORT;
    filter = hit & ent.filter;
    secure = hit & ent.secure;
  end
endmodule

// File: rtl/maclu_engine.sv
module maclu_engine import maclu_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [MAC_W-1:0]   req_mac,
  input  logic               cfg_hash_sel,
  output logic               res_valid,
  input  logic               res_ready,
  output logic               res_hit,
  output logic [PORT_W-1:0]  res_port,
  output logic               res_filter,
  output logic               res_secure,
  input  logic               tbl_we,
  input  logic [IDX_W-1:0]   tbl_idx,
  input  logic [ENTRY_W-1:0] tbl_wdata
);
  logic              stall, accept;
  logic [IDX_W-1:0]  rd_idx;
  logic [ENTRY_W-1:0] rd_word;
  entry_t            rd_ent;
  logic              s1_valid;
  logic [MAC_W-1:0]  s1_mac;
  logic              m_hit, m_filter, m_secure;
  logic [PORT_W-1:0] m_port;

  assign stall     = res_valid & ~res_ready;
  assign req_ready = ~stall;
  assign accept    = req_valid & req_ready;

  maclu_hash u_hash (.sel(cfg_hash_sel), .mac(req_mac), .idx(rd_idx));

  maclu_ram #(.AW(IDX_W), .DW(ENTRY_W)) u_ram (
    .clk(clk), .we(tbl_we), .waddr(tbl_idx), .wdata(tbl_wdata),
    .re(accept), .raddr(rd_idx), .rdata(rd_word)
  );
  assign rd_ent = entry_t'(rd_word);

  // stage 1: key travels beside the table read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mac   <= '0;
    end else if (!stall) begin
      s1_valid <= accept;
      if (accept) s1_mac <= req_mac;
    end
  end

  maclu_match u_match (
    .ent(rd_ent), .key(s1_mac), .hit(m_hit),
    .port(m_port), .filter(m_filter), .secure(m_secure)
  );

  // stage 2: result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_port   <= NOMATCH_PORT;
      res_filter <= 1'b0;
      res_secure <= 1'b0;
    end else if (!stall) begin
      res_valid <= s1_valid;
      if (s1_valid) begin
        res_hit    <= m_hit;
        res_port   <= m_port;
        res_filter <= m_filter;
        res_secure <= m_secure;
      end
    end
  end

  // R4
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_port)
                                   && $stable(res_filter) && $stable(res_secure)));
  // R3
  accept_reaches_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> s1_valid);
  // R3
  stage1_reaches_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && req_ready) |=> res_valid);
  // R9
  miss_reserved_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_port == NOMATCH_PORT && !res_filter && !res_secure));
  // R7
  hit_port_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_port != NOMATCH_PORT));
endmodule

// File: tb/maclu_engine_test.sv
`timescale 1ns/1ps
module maclu_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [47:0] req_mac = '0;
  logic        cfg_hash_sel = 1'b0;
  logic        res_valid, res_ready = 1'b1, res_hit, res_filter, res_secure;
  logic [4:0]  res_port;
  logic        tbl_we = 1'b0;
  logic [10:0] tbl_idx = '0;
  logic [57:0] tbl_wdata = '0;

  always #2.5 clk = ~clk;

  maclu_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mac(req_mac), .cfg_hash_sel(cfg_hash_sel), .res_valid(res_valid),
    .res_ready(res_ready), .res_hit(res_hit), .res_port(res_port),
    .res_filter(res_filter), .res_secure(res_secure), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata)
  );

  typedef struct {logic v; logic hit; logic [4:0] p; logic f; logic s;} res_t;

  int    errors = 0, checks = 0;
  string tag = "R1";
  logic [57:0] tbl [2048];
  res_t  mo, m1;
  logic [47:0] pool [8];

  function automatic logic [10:0] idx_of(logic [47:0] m, logic s);
    if (!s) return m[10:0];
    return m[10:0] ^ m[21:11] ^ m[32:22] ^ m[43:33] ^ {7'd0, m[47:44]};
  endfunction

  function automatic logic [57:0] mk(logic v, logic [47:0] m, logic [4:0] p, logic sec, logic flt);
    return {v, m, p, sec, flt, 2'b00};
  endfunction

  function automatic res_t look(logic [47:0] m, logic s);
    res_t r;
    logic [57:0] e;
    e = tbl[idx_of(m, s)];
    r.v   = 1'b1;
    r.hit = e[57] && (e[56:9] == m) && (e[8:4] != 5'd31);
    r.p   = r.hit ? e[8:4] : 5'd31;
    r.f   = r.hit & e[2];
    r.s   = r.hit & e[3];
    return r;
  endfunction

  task automatic chk(string what, logic [63:0] a, logic [63:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, a, e);
    end
  endtask

  task automatic step(logic rv, logic [47:0] m, logic hs, logic rr,
                      logic we, logic [10:0] wi, logic [57:0] wd);
    res_t nr;
    logic stall;
    @(negedge clk);
    req_valid = rv; req_mac = m; cfg_hash_sel = hs; res_ready = rr;
    tbl_we = we; tbl_idx = wi; tbl_wdata = wd;
    #1;
    chk("R2 req_ready", req_ready, !(mo.v && !rr));
    chk("R3 res_valid", res_valid, mo.v);
    if (mo.v) begin
      chk("R7 R8 R9 res_hit", res_hit, mo.hit);
      chk("R8 R9 res_port", res_port, mo.p);
      chk("R8 R9 res_filter", res_filter, mo.f);
      chk("R8 R9 res_secure", res_secure, mo.s);
    end
    stall = mo.v && !rr;
    nr = '{1'b0, 1'b0, 5'd0, 1'b0, 1'b0};
    if (rv && !stall) nr = look(m, hs);  // before this cycle's write (R11)
    if (!stall) begin
      mo = m1;
      m1 = nr;
    end
    if (we) tbl[wi] = wd;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, '0, '0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [47:0] a, b, c;
    mo = '{1'b0, 1'b0, 5'd0, 1'b0, 1'b0};
    m1 = mo;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1 during reset
    chk("R1 res_valid in reset", res_valid, 1'b0);
    chk("R1 req_ready in reset", req_ready, 1'b1);
    rst_n = 1'b1;
    idle();  // R1 first cycle after reset, through model compare

    tag = "R10";  // clear the table
    for (int i = 0; i < 2048; i++) step(1'b0, '0, 1'b0, 1'b1, 1'b1, 11'(i), mk(1'b0, '0, 5'd0, 1'b0, 1'b0));

    tag = "R5";
    a = 48'h1234_5678_9ABC;
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, idx_of(a, 1'b0), mk(1'b1, a, 5'd3, 1'b0, 1'b1));
    step(1'b1, a, 1'b0, 1'b1, 1'b0, '0, '0);
    b = a ^ (48'h1 << 40);  // same low-bits bucket, different address (R7)
    step(1'b1, b, 1'b0, 1'b1, 1'b0, '0, '0);
    idle(); idle();

    tag = "R6";
    c = 48'hA5C3_0F1E_7D42;
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, idx_of(c, 1'b1), mk(1'b1, c, 5'd17, 1'b1, 1'b0));
    step(1'b1, c, 1'b1, 1'b1, 1'b0, '0, '0);
    step(1'b1, c, 1'b0, 1'b1, 1'b0, '0, '0);
    idle(); idle();

    tag = "R7";
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, idx_of(c, 1'b1), mk(1'b0, c, 5'd17, 1'b1, 1'b0));
    step(1'b1, c, 1'b1, 1'b1, 1'b0, '0, '0);
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, idx_of(c, 1'b1), mk(1'b1, c, 5'd31, 1'b1, 1'b1));
    step(1'b1, c, 1'b1, 1'b1, 1'b0, '0, '0);
    idle(); idle();

    tag = "R11";
    step(1'b1, a, 1'b0, 1'b1, 1'b1, idx_of(a, 1'b0), mk(1'b1, a, 5'd7, 1'b1, 1'b0));
    tag = "R10";
    step(1'b1, a, 1'b0, 1'b1, 1'b0, '0, '0);
    idle(); idle();

    tag = "R12";
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, idx_of(c, 1'b1), mk(1'b1, c, 5'd9, 1'b0, 1'b1));
    for (int i = 0; i < 6; i++) step(1'b1, i[0] ? c : a, i[0], 1'b1, 1'b0, '0, '0);
    idle(); idle();

    tag = "R4";
    step(1'b1, a, 1'b0, 1'b1, 1'b0, '0, '0);
    step(1'b1, c, 1'b1, 1'b1, 1'b0, '0, '0);
    for (int i = 0; i < 4; i++)
      step(1'b1, b, 1'b0, 1'b0, 1'b1, idx_of(c, 1'b1), mk(1'b1, c, 5'(i + 20), 1'b0, 1'b0));
    idle(); idle(); idle();

    tag = "R3";  // randomized traffic with stalls and colliding writes
    for (int i = 0; i < 8; i++) pool[i] = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
    pool[1] = pool[0] ^ (48'h1 << 40);
    for (int i = 0; i < 3000; i++) begin
      logic [47:0] m, wm;
      logic hs, ws;
      m  = pool[$urandom_range(0, 7)];
      hs = 1'($urandom_range(0, 1));
      wm = ($urandom_range(0, 3) == 0) ? m : pool[$urandom_range(0, 7)];
      ws = ($urandom_range(0, 3) == 0) ? hs : 1'($urandom_range(0, 1));
      step(1'($urandom_range(0, 3) != 0), m, hs, 1'($urandom_range(0, 4) != 0),
           1'($urandom_range(0, 4) == 0), idx_of(wm, ws),
           mk(1'($urandom_range(0, 5) != 0), wm,
              ($urandom_range(0, 7) == 0) ? 5'd31 : 5'($urandom_range(0, 23)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))));
    end
    idle(); idle(); idle();

    summary();
    $finish;
  end
endmodule